// File: doc/BRIEF.md
# Sleep Status and Interface Hold Register

This block is a power-manager status register paired with a two-state run/sleep tracker. It records why the chip went to sleep: a CPU-requested forced sleep, a supply (VDD) fault detected while running, or a battery fault seen at any time. It also records that the DRAM and peripheral interfaces are being held after a wake-up. Each of the five flags has its own set condition, and software clears a flag by writing a one to its bit.

Two flags drive outputs. While the DRAM hold flag is set, the memory strobes stay low so the memory remains in self-refresh. While the peripheral hold flag is set, the peripheral pins keep their sleep-state values. Both flags are set when sleep ends, and each interface is released when software clears its flag. The register is cleared only by the power-on reset. The sleep-exit, software and watchdog reset inputs leave it untouched.

Top module: `sleep_status_reg`

## Requirements
- R1: An active-low power-on reset clears all five flags and puts the tracker in run mode.
- R2: Bits 31:5 always read as zero, and writing ones to them changes nothing.
- R3: Writing a one to a flag bit clears that bit on the next clock edge. Writing a zero leaves it unchanged. The bit positions are: 0 forced-sleep status, 1 battery-fault status, 2 VDD-fault status, 3 DRAM hold, 4 peripheral hold.
- R4: When sleep_req is high in run mode, bit 0 is set and sleep mode is entered.
- R5: A high batt_fault sets bit 1 in either mode.
- R6: A high vdd_fault in run mode sets bit 2 and enters sleep. In sleep mode it leaves bit 2 unchanged.
- R7: The sleep-exit, software and watchdog reset inputs have no effect on the register.
- R8: When wake is high in sleep mode, bits 3 and 4 are set and the tracker returns to run. When wake is high in run mode, nothing changes.
- R9: dram_hold equals bit 3 and periph_hold equals bit 4, so each interface is released when software clears its bit.
- R10: When a set condition and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R11: When sleep_req and vdd_fault are both high in run mode, bits 0 and 2 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sleep_exit_rst | input | 1 | Sleep-exit reset, does not affect the register |
| soft_rst | input | 1 | Software reset, does not affect the register |
| wdog_rst | input | 1 | Watchdog reset, does not affect the register |
| sleep_req | input | 1 | CPU forced-sleep request |
| batt_fault | input | 1 | Battery fault input |
| vdd_fault | input | 1 | Supply fault input |
| wake | input | 1 | Wake event |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Write data, one per bit clears a flag |
| rdata | output | 32 | Register readback |
| dram_hold | output | 1 | Holds the memory strobes low |
| periph_hold | output | 1 | Freezes the peripheral pins |

## Verification
Every flag and the mode bit are registered, and the readback is combinational. A wrong flag therefore shows up on rdata and on the hold outputs one clock edge after the event that caused it. A wrong mode bit cannot be read directly. It shows up only at the next sleep_req, vdd_fault or wake, through a VDD-fault flag that sets when it should not (or stays clear when it should set), or through hold flags that appear or go missing. For this reason the stimulus follows each mode change with a fault or wake event that exposes the mode.

// File: rtl/sleep_status_reg.sv
module sleep_status_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sleep_exit_rst,
  input  logic              soft_rst,
  input  logic              wdog_rst,
  input  logic              sleep_req,
  input  logic              batt_fault,
  input  logic              vdd_fault,
  input  logic              wake,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              dram_hold,
  output logic              periph_hold
);
  localparam int FLAG_W  = 5;
  localparam int SW_B    = 0;
  localparam int BATT_B  = 1;
  localparam int VDD_B   = 2;
  localparam int DRAM_B  = 3;
  localparam int PERIPH_B = 4;

  logic [FLAG_W-1:0] flags, set_vec, clr_vec;
  logic asleep;

  wire in_run   = !asleep;
  wire wake_evt = asleep & wake;

  assign set_vec = {wake_evt, wake_evt, in_run & vdd_fault, batt_fault, in_run & sleep_req};
  assign clr_vec = wr_en ? wdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flags  <= '0;
      asleep <= 1'b0;
    end else begin
      flags  <= set_vec | (flags & ~clr_vec);
      asleep <= asleep ? !wake : (sleep_req | vdd_fault);
    end
  end

  assign rdata       = {{(DATA_W-FLAG_W){1'b0}}, flags};
  assign dram_hold   = flags[DRAM_B];
  assign periph_hold = flags[PERIPH_B];

  // R2
  reserved_ignored_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && |wdata[DATA_W-1:FLAG_W]) |=> (rdata[DATA_W-1:FLAG_W] == '0));

  // R5
  batt_any_mode_chk: assert property (@(posedge clk) disable iff (!por_n)
    batt_fault |=> rdata[BATT_B]);

  // R6
  vdd_sleep_ignored_chk: assert property (@(posedge clk) disable iff (!por_n)
    (asleep && !flags[VDD_B]) |=> !rdata[VDD_B]);

  // R8
  wake_holds_chk: assert property (@(posedge clk) disable iff (!por_n)
    (asleep && wake) |=> (dram_hold && periph_hold));

  // R3
  sw_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wdata[SW_B] && !(in_run && sleep_req)) |=> !rdata[SW_B]);

  // R7
  other_resets_chk: assert property (@(posedge clk) disable iff (!por_n)
    ((sleep_exit_rst || soft_rst || wdog_rst) && !wr_en && !sleep_req &&
     !batt_fault && !vdd_fault && !wake) |=> $stable(rdata));
endmodule

// File: tb/sleep_status_reg_bench.sv
module sleep_status_reg_bench;
  logic clk = 0;
  logic por_n = 0;
  logic sleep_exit_rst = 0, soft_rst = 0, wdog_rst = 0;
  logic sleep_req = 0, batt_fault = 0, vdd_fault = 0, wake = 0, wr_en = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic dram_hold, periph_hold;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [4:0] m_flags = '0;
  bit m_sleep = 0;
  logic [33:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  sleep_status_reg u_sleep_status_reg (
    .clk(clk), .por_n(por_n), .sleep_exit_rst(sleep_exit_rst), .soft_rst(soft_rst),
    .wdog_rst(wdog_rst), .sleep_req(sleep_req), .batt_fault(batt_fault),
    .vdd_fault(vdd_fault), .wake(wake), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .dram_hold(dram_hold), .periph_hold(periph_hold));

  task automatic compare(string tag, logic [33:0] exp);
    logic [33:0] act;
    act = {periph_hold, dram_hold, rdata};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus; the model computes the state after the next edge.
  task automatic step(string tag, bit sf, bit bf, bit vf, bit wk, bit we,
                      logic [31:0] wd, bit rx = 0, bit rs = 0, bit rw = 0);
    logic [4:0] set_v, clr_v;
    @(negedge clk);
    sleep_req = sf; batt_fault = bf; vdd_fault = vf; wake = wk;
    wr_en = we; wdata = wd; sleep_exit_rst = rx; soft_rst = rs; wdog_rst = rw;
    set_v = {m_sleep & wk, m_sleep & wk, !m_sleep & vf, bf, !m_sleep & sf};
    clr_v = we ? wd[4:0] : 5'b0;
    m_flags = set_v | (m_flags & ~clr_v);
    m_sleep = m_sleep ? !wk : (sf | vf);
    exp_q.push_back({m_flags[4], m_flags[3], 27'b0, m_flags});
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) compare(tag_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    compare("R1 reset state", 34'h0);
    @(negedge clk);
    por_n = 1;
    step("R2 write ones to empty reg", 0, 0, 0, 0, 1, 32'hFFFF_FFFF);
    step("R8 wake in run ignored", 0, 0, 0, 1, 0, 0);
    step("R4 forced sleep sets bit0", 1, 0, 0, 0, 0, 0);
    step("R6 vdd fault in sleep ignored", 0, 0, 1, 0, 0, 0);
    step("R5 battery fault in sleep", 0, 1, 0, 0, 0, 0);
    step("R8 wake sets holds", 0, 0, 0, 1, 0, 0);
    step("R7 sleep-exit reset", 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step("R7 software reset", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R7 watchdog reset", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R3 write zeros no effect", 0, 0, 0, 0, 1, 32'h0);
    step("R2 reserved writes ignored", 0, 0, 0, 0, 1, 32'hFFFF_FFE0);
    step("R9 clear DRAM hold", 0, 0, 0, 0, 1, 32'h8);
    step("R9 clear peripheral hold", 0, 0, 0, 0, 1, 32'h10);
    step("R3 clear bit0 and bit1", 0, 0, 0, 0, 1, 32'h3);
    step("R6 vdd fault in run", 0, 0, 1, 0, 0, 0);
    step("R6 second vdd fault asleep", 0, 0, 1, 0, 1, 32'h4);
    step("R8 wake after vdd sleep", 0, 0, 0, 1, 0, 0);
    step("R10 battery set beats clear", 0, 1, 0, 0, 1, 32'h2);
    step("R3 clear all", 0, 0, 0, 0, 1, 32'hFFFF_FFFF);
    step("R11 sleep_req with vdd fault", 1, 0, 1, 0, 0, 0);
    step("R10 wake set beats hold clear", 0, 0, 0, 1, 1, 32'h18);
    step("R10 forced sleep beats clear", 1, 0, 0, 0, 1, 32'h1);
    step("R11 wake returns to run", 0, 0, 0, 1, 0, 0);
    step("R4 run mode after wake", 0, 0, 0, 0, 1, 32'h1F);
    step("R4 forced sleep again", 1, 0, 0, 0, 0, 0);
    step("R7 all resets together", 0, 0, 0, 0, 0, 0, 1, 1, 1);
    @(negedge clk);
    sleep_req = 0; sleep_exit_rst = 0; soft_rst = 0; wdog_rst = 0; wr_en = 0;
    repeat (2) @(posedge clk);
    #2;
    @(negedge clk);
    por_n = 0;
    #1;
    compare("R1 power-on reset clears", 34'h0);
    @(negedge clk);
    por_n = 1;
    m_flags = '0; m_sleep = 0;
    step("R1 run mode after reset", 0, 0, 1, 0, 0, 0);
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule